// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block gives software four doorbell channels for signalling between processors. Each channel holds two pieces of state:

- a vector/priority word;
- a destination mask with one bit per CPU.

Any CPU writes a channel's dispatch register to send the doorbell. The written bits are ORed into that channel's destination mask. The block then emits a one-cycle event pulse toward the downstream interrupt routing logic, which treats the pulse as an edge on that channel's source input.

Delivery drains the mask one CPU at a time. When a CPU acknowledges a channel, through a per-CPU strobe that carries a channel index, that CPU's bit leaves the mask. If other targets remain and the channel is edge-sensitive, the block re-fires the event so the routing logic can deliver to the CPUs that have not taken it yet. Priority arbitration between channels for each CPU is the job of the routing logic, not of this block.

Register accesses sit in one address space. The dispatch registers are at offsets 0x40, 0x50, 0x60 and 0x70, for channels 0 to 3. The vector/priority words are at 0x10A0, 0x10B0, 0x10C0 and 0x10D0. Reads are combinational.

Top module: `ipi_dispatcher`

## Requirements
- R1: After reset every destination mask reads 0, every vector/priority word reads 0x80000000, and no event pulse is driven.
- R2: A write to dispatch offset 0x40+16*c ORs the low NUM_CPUS bits of the data into channel c's mask. A read of the same offset returns that mask, zero-extended.
- R3: A dispatch write to channel c drives fireEvent[c] high for exactly the one cycle after the write, and sets that channel's activity bit (bit 30 of its vector/priority word).
- R4: An acknowledge from CPU n carrying channel index c clears bit n of channel c's mask on the next clock. Acknowledges from several CPUs to one channel in the same cycle clear all their bits.
- R5: After an acknowledge the mask may still be nonzero. If it is, and the channel's sense bit (bit 22) is 0 (edge), fireEvent[c] pulses in the next cycle and the activity bit reads 1.
- R6: If the sense bit is 1 (level), an acknowledge that leaves the mask nonzero produces no event pulse.
- R7: An acknowledge that empties the mask, with no dispatch write in the same cycle, produces no pulse and clears the activity bit.
- R8: A vector/priority word at 0x10A0+16*c keeps only write bits 31, 22, 19:16 and 7:0, so the write mask is 0x804F00FF. Bit 30 is read-only and reports activity.
- R9: A write to an offset whose low four bits are nonzero changes nothing. A read of such an offset, or of any unmapped offset, returns 0xFFFFFFFF.
- R10: A dispatch write and an acknowledge to the same channel in the same cycle give mask = (old & ~acked) | written, and the cycle produces one event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| ackValid | input | NUM_CPUS | Per-CPU acknowledge strobe |
| ackChan | input | NUM_CPUS*2 | Per-CPU acknowledged channel index, CPU n at bits [2n+1:2n] |
| fireEvent | output | 4 | Per-channel one-cycle event pulse toward the routing logic |

## Verification
The assertions check on every cycle:

- a dispatch write leaves every written bit set in the mask;
- an acknowledge without a colliding write clears its CPU's bit;
- an event pulse is always preceded by a write or an acknowledge on its channel;
- a level-sensitive channel never re-fires after an acknowledge;
- a vector/priority write alone leaves the activity bit unchanged;
- unaligned offsets raise no strobe.

Only the directed scenarios show the following:

- reset values;
- exact readback values after masking;
- the single-cycle width of each pulse;
- activity clearing when the mask empties;
- the merged mask value when a write and an acknowledge collide.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int IPI_CHANNELS = 4;
  localparam int CH_IDX_W     = $clog2(IPI_CHANNELS);
  localparam int DATA_W       = 32;
  localparam int CH_STRIDE    = 16;
  localparam int DISP_BASE    = 32'h0000_0040;
  localparam int VP_BASE      = 32'h0000_10A0;
  localparam logic [DATA_W-1:0] VP_WR_MASK = 32'h804F_00FF;
  localparam logic [DATA_W-1:0] VP_RESET   = 32'h8000_0000;
  localparam int ACTIVE_BIT   = 30;
  localparam int SENSE_BIT    = 22;

  typedef struct packed {
    logic [IPI_CHANNELS-1:0] dispWr;
    logic [IPI_CHANNELS-1:0] vpWr;
    logic [IPI_CHANNELS-1:0] dispRd;
    logic [IPI_CHANNELS-1:0] vpRd;
  } regStrobes_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [NUM_CPUS-1:0]           ackValid,
  input  logic [NUM_CPUS*CH_IDX_W-1:0]  ackChan,
  output regStrobes_t                   strobes,
  output logic [IPI_CHANNELS-1:0][NUM_CPUS-1:0] ackClr
);
  logic aligned;
  assign aligned = (regAddr[3:0] == 4'h0);

  for (genvar c = 0; c < IPI_CHANNELS; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] DISP_OFS = ADDR_W'(DISP_BASE + c * CH_STRIDE);
    localparam logic [ADDR_W-1:0] VP_OFS   = ADDR_W'(VP_BASE + c * CH_STRIDE);
    logic hitDisp, hitVp;
    assign hitDisp = aligned && (regAddr == DISP_OFS);
    assign hitVp   = aligned && (regAddr == VP_OFS);
    assign strobes.dispWr[c] = regWrEn && hitDisp;
    assign strobes.vpWr[c]   = regWrEn && hitVp;
    assign strobes.dispRd[c] = hitDisp;
    assign strobes.vpRd[c]   = hitVp;
    for (genvar n = 0; n < NUM_CPUS; n++) begin : g_ack
      assign ackClr[c][n] = ackValid[n] &&
                            (ackChan[n*CH_IDX_W +: CH_IDX_W] == CH_IDX_W'(c));
    end
  end

  // R9: an unaligned offset must not reach any register
  assert_unaligned_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[3:0] != 4'h0) |-> (strobes == '0));
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  regStrobes_t                           strobes,
  input  logic [IPI_CHANNELS-1:0][NUM_CPUS-1:0] ackClr,
  input  logic [DATA_W-1:0]                     wrData,
  output logic [DATA_W-1:0]                     rdData,
  output logic [IPI_CHANNELS-1:0]               fireEvent
);
  logic [NUM_CPUS-1:0] destMask [IPI_CHANNELS];
  logic [DATA_W-1:0]   vpStore  [IPI_CHANNELS];
  logic [IPI_CHANNELS-1:0] active, fireQ, ackAny, refire;
  logic [NUM_CPUS-1:0] remaining [IPI_CHANNELS];
  logic [NUM_CPUS-1:0] wrBits;

  assign wrBits = wrData[NUM_CPUS-1:0];

  for (genvar c = 0; c < IPI_CHANNELS; c++) begin : g_ch
    assign ackAny[c]    = |ackClr[c];
    assign remaining[c] = destMask[c] & ~ackClr[c];
    assign refire[c]    = ackAny[c] && (|remaining[c]) && !vpStore[c][SENSE_BIT];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        destMask[c] <= '0;
        vpStore[c]  <= VP_RESET;
        active[c]   <= 1'b0;
        fireQ[c]    <= 1'b0;
      end else begin
        if (strobes.dispWr[c])   destMask[c] <= remaining[c] | wrBits;
        else if (ackAny[c])      destMask[c] <= remaining[c];
        if (strobes.vpWr[c])     vpStore[c]  <= wrData & VP_WR_MASK;
        fireQ[c] <= strobes.dispWr[c] || refire[c];
        if (strobes.dispWr[c] || refire[c])        active[c] <= 1'b1;
        else if (ackAny[c] && !(|remaining[c]))    active[c] <= 1'b0;
      end
    end

    // R2: every written bit is present in the mask afterwards
    assert_or_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.dispWr[c] |=> ((destMask[c] & $past(wrBits)) == $past(wrBits)));
    // R3: a pulse always has a cause on its own channel one cycle earlier
    assert_fire_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
      fireQ[c] |-> $past(strobes.dispWr[c] || ackAny[c]));
    // R6: level-sensitive channels never re-fire on acknowledge
    assert_level_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ackAny[c] && !strobes.dispWr[c] && vpStore[c][SENSE_BIT]) |=> !fireQ[c]);
    // R8: writing the vector/priority word alone leaves activity alone
    assert_active_ro_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.vpWr[c] && !strobes.dispWr[c] && !ackAny[c]) |=> (active[c] == $past(active[c])));

    for (genvar n = 0; n < NUM_CPUS; n++) begin : g_cpu
      // R4: acknowledging CPU leaves the mask
      assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
        (ackClr[c][n] && !strobes.dispWr[c]) |=> !destMask[c][n]);
    end
  end

  always_comb begin
    rdData = '1;
    for (int c = 0; c < IPI_CHANNELS; c++) begin
      if (strobes.dispRd[c]) rdData = DATA_W'(destMask[c]);
      if (strobes.vpRd[c]) begin
        rdData = vpStore[c];
        rdData[ACTIVE_BIT] = active[c];
      end
    end
  end

  assign fireEvent = fireQ;
endmodule

// File: rtl/ipi_dispatcher.sv
module ipi_dispatcher
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWrData,
  output logic [DATA_W-1:0]             regRdData,
  input  logic [NUM_CPUS-1:0]           ackValid,
  input  logic [NUM_CPUS*CH_IDX_W-1:0]  ackChan,
  output logic [IPI_CHANNELS-1:0]       fireEvent
);
  regStrobes_t strobes;
  logic [IPI_CHANNELS-1:0][NUM_CPUS-1:0] ackClr;

  ipi_ctrl #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .ackValid(ackValid), .ackChan(ackChan), .strobes(strobes), .ackClr(ackClr)
  );

  ipi_datapath #(.NUM_CPUS(NUM_CPUS)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ackClr(ackClr),
    .wrData(regWrData), .rdData(regRdData), .fireEvent(fireEvent)
  );
endmodule

// File: tb/tb_ipi_dispatcher.sv
module tb_ipi_dispatcher;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NCPU-1:0] ackValid = '0;
  logic [NCPU*2-1:0] ackChan = '0;
  logic [3:0] fireEvent;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dispatcher #(.NUM_CPUS(NCPU), .ADDR_W(16)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ackValid(ackValid),
    .ackChan(ackChan), .fireEvent(fireEvent)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one clock of stimulus; at return the registered results are visible
  task automatic cycle(input logic wr, input logic [15:0] a, input logic [31:0] d,
                       input logic [NCPU-1:0] av, input logic [NCPU*2-1:0] ac);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; ackValid = av; ackChan = ac;
    @(negedge clk);
    regWrEn = 1'b0; ackValid = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      rd(16'h0040 + 16'(c*16), v); check("R1 mask reset", v, 32'h0);
      rd(16'h10A0 + 16'(c*16), v); check("R1 vp reset", v, 32'h8000_0000);
    end
    check("R1 no fire", 32'(fireEvent), 32'h0);
  endtask

  task automatic t_dispatch();
    logic [31:0] v;
    cycle(1'b1, 16'h0050, 32'h5, '0, '0);
    check("R3 pulse ch1", 32'(fireEvent), 32'h2);
    rd(16'h0050, v); check("R2 mask ch1", v, 32'h5);
    cycle(1'b1, 16'h0050, 32'hFFFF_FFF2, '0, '0);
    rd(16'h0050, v); check("R2 OR ch1", v, 32'h7);
    @(negedge clk);
    check("R3 pulse one cycle", 32'(fireEvent), 32'h0);
    rd(16'h10B0, v); check("R3 activity set", 32'(v[30]), 32'h1);
  endtask

  task automatic t_vp();
    logic [31:0] v;
    cycle(1'b1, 16'h10A0, 32'hFFFF_FFFF, '0, '0);
    rd(16'h10A0, v); check("R8 vp mask", v, 32'h804F_00FF);
    cycle(1'b1, 16'h10B0, 32'h0, '0, '0);
    rd(16'h10B0, v); check("R8 activity read-only", v, 32'h4000_0000);
  endtask

  task automatic t_ack_edge();
    logic [31:0] v;
    // CPU0 acks channel 1 (mask 7, edge)
    cycle(1'b0, 16'h0, 32'h0, 4'b0001, 8'b00_00_00_01);
    check("R5 refire ch1", 32'(fireEvent), 32'h2);
    rd(16'h0050, v); check("R4 clear cpu0", v, 32'h6);
    rd(16'h10B0, v); check("R5 activity", 32'(v[30]), 32'h1);
    // CPU1 and CPU2 ack channel 1 together
    cycle(1'b0, 16'h0, 32'h0, 4'b0110, 8'b00_01_01_00);
    check("R7 no pulse on empty", 32'(fireEvent), 32'h0);
    rd(16'h0050, v); check("R4 multi clear", v, 32'h0);
    rd(16'h10B0, v); check("R7 activity cleared", 32'(v[30]), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    cycle(1'b1, 16'h10C0, 32'h0040_0000, '0, '0);
    cycle(1'b1, 16'h0060, 32'h3, '0, '0);
    check("R3 pulse ch2", 32'(fireEvent), 32'h4);
    cycle(1'b0, 16'h0, 32'h0, 4'b0001, 8'b00_00_00_10);
    check("R6 level no refire", 32'(fireEvent), 32'h0);
    rd(16'h0060, v); check("R4 clear ch2", v, 32'h2);
  endtask

  task automatic t_unaligned();
    logic [31:0] v;
    cycle(1'b1, 16'h0064, 32'hF, '0, '0);
    check("R9 no pulse", 32'(fireEvent), 32'h0);
    rd(16'h0060, v); check("R9 mask kept", v, 32'h2);
    rd(16'h0064, v); check("R9 unaligned read", v, 32'hFFFF_FFFF);
    rd(16'h0200, v); check("R9 unmapped read", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    cycle(1'b1, 16'h0070, 32'h3, '0, '0);
    cycle(1'b1, 16'h0070, 32'h1, 4'b0001, 8'b00_00_00_11);
    check("R10 pulse", 32'(fireEvent), 32'h8);
    rd(16'h0070, v); check("R10 merge same bit", v, 32'h3);
    cycle(1'b1, 16'h0070, 32'h4, 4'b0010, 8'b00_00_11_00);
    rd(16'h0070, v); check("R10 merge", v, 32'h5);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_dispatch();
    t_vp();
    t_ack_edge();
    t_level();
    t_unaligned();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule